// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave on a two-wire serial bus. An external master uses it to read and write an internal space of byte-wide registers. The bus clock and data lines are oversampled with a fast system clock. Each line passes through a synchronizer, and bus events are decoded from the synchronized levels. The data line is open-drain: the block only ever asserts a "pull low" enable.

A transaction begins with a START and an address byte that carries a direction flag. On a write, the first data byte sets the register pointer and each later byte is written to the core. On a read, the master first writes the pointer, then issues a repeated START and the address with the read flag. The slave then sends bytes from the pointer onward until the master answers with a not-acknowledge. The core sees a simple register port: address, write data, a one-cycle write strobe, read data sampled combinationally, and a one-cycle read strobe.

Top module: `twire_reg_slave`

## Requirements
- R1: A START (data falling while clock high) enters the address phase from any state. A STOP (data rising while clock high) ends the transaction and releases the data line.
- R2: If the seven address bits received MSB first equal DEV_ADDR (default 0x74), the slave pulls data low during the ninth clock. This holds for both direction flags (bit 0 of the byte: 1 = read, 0 = write).
- R3: If the address does not match, the slave gives no acknowledge. It then leaves the line released and raises no strobe until the next START.
- R4: The first byte after an address with the write flag loads the register pointer and is acknowledged. It raises no write strobe.
- R5: Each later written byte is acknowledged and raises `reg_we_o` for exactly one cycle. During that cycle `reg_addr_o` holds the pointer and `reg_wdata_o` holds the byte, assembled MSB first.
- R6: The pointer advances by one after each written or read data byte and wraps at its width. It keeps its value between transactions and is zero after reset.
- R7: For each byte it sends, the slave raises `reg_re_o` for one cycle, takes `reg_rdata_i` in that cycle, and shifts the byte out MSB first. Each bit changes only after a falling clock edge.
- R8: When the master acknowledges a read byte, the next byte is fetched. When the master does not acknowledge, the slave stops fetching and releases the line.
- R9: After reset all outputs are low. The data line is released at all times except during an acknowledge or a read bit that is 0.
- R10: A repeated START behaves like a START. A pointer write followed by a repeated START and a read returns the register at that pointer.
- R11: A STOP in the middle of a byte discards the partial byte without any strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired line) |
| sda_oe_o | output | 1 | 1 = pull data line low, 0 = release |
| reg_addr_o | output | PTR_W | Register pointer toward the core |
| reg_wdata_o | output | 8 | Write data, valid with reg_we_o |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe; reg_rdata_i is taken in this cycle |
| reg_rdata_i | input | 8 | Read data for reg_addr_o |

## Verification
The bench builds the block with its defaults: DEV_ADDR 0x74, an 8-bit pointer and a two-stage synchronizer. The 8-bit pointer lets a write at 0xFF followed by a read show the wrap to 0x00. A bus quarter-bit of eight system clocks leaves room for the three-cycle synchronizer and edge latency before every level change. That spacing lets the bench sample acknowledge and read bits in the middle of the clock-high phase.

// File: rtl/twire_pkg.sv
package twire_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WRITE,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_LOAD,
        ST_READ,
        ST_MACK
    } twire_state_e;

endpackage

// File: rtl/twire_edge_sync.sv
module twire_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t sy_d, sy_q;
    logic  scl_s, sda_s;

    assign scl_s = sy_q.scl_sh[STAGES-1];
    assign sda_s = sy_q.sda_sh[STAGES-1];

    always_comb begin
        sy_d        = sy_q;
        sy_d.scl_sh = {sy_q.scl_sh[STAGES-2:0], scl_i};
        sy_d.sda_sh = {sy_q.sda_sh[STAGES-2:0], sda_i};
        sy_d.scl_p  = scl_s;
        sy_d.sda_p  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '1;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign sda_s_o    = sda_s;
    assign scl_rise_o = scl_s & ~sy_q.scl_p;
    assign scl_fall_o = ~scl_s & sy_q.scl_p;
    assign start_o    = scl_s & sy_q.scl_p & sy_q.sda_p & ~sda_s;
    assign stop_o     = scl_s & sy_q.scl_p & ~sy_q.sda_p & sda_s;

    AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}))
        else $error("bus events overlap"); // R1

endmodule

// File: rtl/twire_byte_fsm.sv
module twire_byte_fsm
    import twire_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h74,
    parameter int         PTR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [BYTE_W-1:0] rdata,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  addr,
    output logic [BYTE_W-1:0] wdata,
    output logic              we,
    output logic              re
);

    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
    localparam logic [2:0]       LAST_BIT = 3'd7;

    typedef struct packed {
        twire_state_e      state;
        logic [BYTE_W-1:0] shift;
        logic [2:0]        bit_cnt;
        logic              rw;
        logic              first;
        logic              more;
        logic              oe;
        logic              we;
        logic              re;
        logic [PTR_W-1:0]  ptr;
    } fsm_t;

    fsm_t              f_d, f_q;
    logic [BYTE_W-1:0] byte_in;

    assign byte_in = {f_q.shift[BYTE_W-2:0], sda_s};

    always_comb begin
        f_d    = f_q;
        f_d.we = 1'b0;
        f_d.re = 1'b0;
        if (f_q.we) begin
            f_d.ptr = f_q.ptr + PTR_ONE;
        end
        if (start_ev) begin
            f_d.state   = ST_ADDR;
            f_d.bit_cnt = '0;
            f_d.first   = 1'b1;
            f_d.oe      = 1'b0;
        end else if (stop_ev) begin
            f_d.state = ST_IDLE;
            f_d.oe    = 1'b0;
        end else begin
            case (f_q.state)
                ST_ADDR, ST_WRITE: begin
                    if (scl_rise) begin
                        f_d.shift   = byte_in;
                        f_d.bit_cnt = f_q.bit_cnt + 3'd1;
                        if (f_q.bit_cnt == LAST_BIT) begin
                            if (f_q.state == ST_ADDR) begin
                                if (byte_in[7:1] == DEV_ADDR) begin
                                    f_d.rw    = byte_in[0];
                                    f_d.state = ST_ACK_WAIT;
                                end else begin
                                    f_d.state = ST_IDLE;
                                end
                            end else begin
                                if (f_q.first) begin
                                    f_d.ptr   = PTR_W'(byte_in);
                                    f_d.first = 1'b0;
                                end else begin
                                    f_d.we = 1'b1;
                                end
                                f_d.state = ST_ACK_WAIT;
                            end
                        end
                    end
                end
                ST_ACK_WAIT: begin
                    if (scl_fall) begin
                        f_d.oe    = 1'b1;
                        f_d.state = ST_ACK_DRIVE;
                    end
                end
                ST_ACK_DRIVE: begin
                    if (scl_fall) begin
                        f_d.oe      = 1'b0;
                        f_d.bit_cnt = '0;
                        if (f_q.rw) begin
                            f_d.re    = 1'b1;
                            f_d.state = ST_LOAD;
                        end else begin
                            f_d.state = ST_WRITE;
                        end
                    end
                end
                ST_LOAD: begin
                    f_d.shift   = rdata;
                    f_d.oe      = ~rdata[BYTE_W-1];
                    f_d.ptr     = f_q.ptr + PTR_ONE;
                    f_d.bit_cnt = '0;
                    f_d.state   = ST_READ;
                end
                ST_READ: begin
                    if (scl_fall) begin
                        if (f_q.bit_cnt == LAST_BIT) begin
                            f_d.oe    = 1'b0;
                            f_d.state = ST_MACK;
                        end else begin
                            f_d.bit_cnt = f_q.bit_cnt + 3'd1;
                            f_d.shift   = {f_q.shift[BYTE_W-2:0], 1'b0};
                            f_d.oe      = ~f_q.shift[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        f_d.more = ~sda_s;
                    end
                    if (scl_fall) begin
                        if (f_q.more) begin
                            f_d.re    = 1'b1;
                            f_d.state = ST_LOAD;
                        end else begin
                            f_d.state = ST_IDLE;
                        end
                    end
                end
                default: begin
                    f_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q       <= '0;
            f_q.state <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign sda_oe = f_q.oe;
    assign addr   = f_q.ptr;
    assign wdata  = f_q.shift;
    assign we     = f_q.we;
    assign re     = f_q.re;

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we) else $error("write strobe longer than one cycle"); // R5
    AST_RE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> !re) else $error("read strobe longer than one cycle"); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we, re})) else $error("read and write strobes together"); // R7
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> addr == $past(addr) + PTR_ONE) else $error("pointer did not step"); // R6
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe) else $error("line held after stop"); // R1
    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == ST_IDLE) |-> (!sda_oe && !we && !re)) else $error("activity while idle"); // R3

endmodule

// File: rtl/twire_reg_slave.sv
module twire_reg_slave
    import twire_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h74,
    parameter int         PTR_W       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [PTR_W-1:0]  reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    output logic              reg_re_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);

    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    twire_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    twire_byte_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .PTR_W    (PTR_W)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rdata    (reg_rdata_i),
        .sda_oe   (sda_oe_o),
        .addr     (reg_addr_o),
        .wdata    (reg_wdata_o),
        .we       (reg_we_o),
        .re       (reg_re_o)
    );

endmodule

// File: tb/test_twire_reg_slave.sv
module test_twire_reg_slave;

    localparam int Q = 8;
    localparam logic [7:0] ADR_W = 8'hE8;
    localparam logic [7:0] ADR_R = 8'hE9;
    localparam logic [15:0] VEC [0:5] = '{16'h005A, 16'h01A5, 16'h7F00,
                                          16'h80FF, 16'hFF3C, 16'h1081};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_re;
    logic [7:0] mem [0:255];
    int         we_cnt = 0, re_cnt = 0;
    logic [7:0] last_waddr, last_wdata;
    int         checks = 0, errors = 0;

    always #4 clk = ~clk;

    assign sda_bus   = m_sda & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    twire_reg_slave i_twire_reg_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_oe_o    (sda_oe),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_we_o    (reg_we),
        .reg_re_o    (reg_re),
        .reg_rdata_i (reg_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h55;
        end else begin
            if (reg_we) begin
                mem[reg_addr] <= reg_wdata;
                last_waddr    <= reg_addr;
                last_wdata    <= reg_wdata;
                we_cnt        <= we_cnt + 1;
            end
            if (reg_re) re_cnt <= re_cnt + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic qw;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; qw; scl = 1'b1; qw; m_sda = 1'b0; qw; scl = 1'b0; qw;
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; qw; scl = 1'b1; qw; m_sda = 1'b1; qw;
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; qw; scl = 1'b1; qw; scl = 1'b0; qw;
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; qw; scl = 1'b1; qw; ack = ~sda_bus; scl = 1'b0; qw;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw; scl = 1'b1; qw; b[i] = sda_bus; scl = 1'b0;
        end
        qw; m_sda = ~give_ack; qw; scl = 1'b1; qw; scl = 1'b0; qw; m_sda = 1'b1;
    endtask

    task automatic read_one(input logic [7:0] ptr, output logic [7:0] d,
                            output logic a0, output logic a1, output logic a2);
        bus_start; wbyte(ADR_W, a0); wbyte(ptr, a1);
        bus_start; wbyte(ADR_R, a2); rbyte(1'b0, d); bus_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act %h exp %h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic       a0, a1, a2, a3;
        logic [7:0] d, d1, d2;
        int         wc, rc;
        repeat (4) @(negedge clk);
        // R9 reset state, R6 pointer zero after reset
        chk(!sda_oe && !reg_we && !reg_re, "R9 reset outputs", {sda_oe, reg_we, reg_re}, 0);
        chk(reg_addr == 8'h00, "R6 reset pointer", reg_addr, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Vector table: write {ptr,data}, then read it back through a repeated START
        for (int v = 0; v < 6; v++) begin
            logic [7:0] p, x;
            p = VEC[v][15:8];
            x = VEC[v][7:0];
            wc = we_cnt;
            bus_start; wbyte(ADR_W, a0); wbyte(p, a1); wbyte(x, a2); bus_stop;
            chk(a0, "R2 address ack (write)", a0, 1);
            chk(a1, "R4 pointer byte ack", a1, 1);
            chk(a2 && we_cnt == wc + 1, "R5 one strobe per data byte", we_cnt - wc, 1);
            chk(last_waddr == p && last_wdata == x, "R5 strobe address/data",
                {last_waddr, last_wdata}, {p, x});
            chk(!sda_oe, "R1 released after stop", sda_oe, 0);
            read_one(p, d, a0, a1, a3);
            chk(a3, "R2 address ack (read)", a3, 1);
            chk(d == x, "R10 read after repeated start", d, x);
            chk(reg_addr == p + 8'd1, "R6 pointer after read (wraps)", reg_addr, p + 8'd1);
        end

        // R3 address mismatch: no ack, no strobes
        wc = we_cnt;
        rc = re_cnt;
        bus_start; wbyte(8'hEA, a0); wbyte(8'h40, a1); wbyte(8'h77, a2); bus_stop;
        chk(!a0, "R3 mismatch not acknowledged", a0, 0);
        chk(!a1 && !a2 && we_cnt == wc && re_cnt == rc, "R3 no activity after mismatch",
            we_cnt - wc, 0);
        read_one(8'h40, d, a0, a1, a2);
        chk(d == (8'h40 ^ 8'h55), "R3 register untouched", d, 8'h40 ^ 8'h55);

        // R6 auto increment on multi-byte write, R8 multi-byte read with acks
        wc = we_cnt;
        bus_start; wbyte(ADR_W, a0); wbyte(8'h20, a1);
        wbyte(8'h11, a1); wbyte(8'h22, a2); wbyte(8'h33, a3); bus_stop;
        chk(we_cnt == wc + 3 && reg_addr == 8'h23, "R6 pointer after 3 writes", reg_addr, 8'h23);
        rc = re_cnt;
        bus_start; wbyte(ADR_W, a0); wbyte(8'h20, a1);
        bus_start; wbyte(ADR_R, a2);
        rbyte(1'b1, d); rbyte(1'b1, d1); rbyte(1'b0, d2);
        chk(!sda_oe, "R8 released after master nack", sda_oe, 0);
        bus_stop;
        chk(d == 8'h11 && d1 == 8'h22 && d2 == 8'h33, "R8 burst read data",
            {d, d1, d2}, 24'h112233);
        chk(re_cnt == rc + 3, "R7 one read strobe per byte, none after nack", re_cnt - rc, 3);

        // R6 pointer persists: read with no pointer write continues at 0x23
        bus_start; wbyte(ADR_R, a0); rbyte(1'b0, d); bus_stop;
        chk(a0 && d == (8'h23 ^ 8'h55), "R6 read continues at kept pointer", d, 8'h23 ^ 8'h55);

        // R11 STOP in the middle of a data byte
        wc = we_cnt;
        bus_start; wbyte(ADR_W, a0); wbyte(8'h30, a1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop;
        chk(we_cnt == wc, "R11 partial byte discarded", we_cnt - wc, 0);
        chk(reg_addr == 8'h30, "R4 pointer loaded without strobe", reg_addr, 8'h30);
        read_one(8'h30, d, a0, a1, a2);
        chk(d == (8'h30 ^ 8'h55), "R11 register unchanged", d, 8'h30 ^ 8'h55);
        chk(!sda_oe, "R9 line released when idle", sda_oe, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule